// File: doc/BRIEF.md
# Per-Channel CAS Signaling Source Selector

This block sits on the transmit side of an E1 framer, in the serial path that carries timeslot 16. Timeslot 16 holds the channel-associated signaling. For each signaling nibble in that timeslot, the block decides where the four bits come from. They can come from the serial transmit stream as it arrives, or from a bank of sixteen internal signaling bytes. A master enable switches the per-channel choice on. While the enable is clear, every bit passes through untouched.

A multiframe is 16 frames, each made of 32 timeslots of 8 bits. Upstream logic marks every serial bit with its frame, timeslot and bit index. In frame n (1 to 15), the upper nibble of timeslot 16 belongs to channel n and the lower nibble belongs to channel n+16. In frame 0 the timeslot carries the multiframe alignment word in its upper nibble and the spare and remote-alarm bits in its lower nibble. Internal signaling byte 0 supplies these bits, gated by the select bits of channels 1 and 17.

Settings are loaded through a simple byte write port into a staging copy. The staging copy is moved into the working copy only at the start of a multiframe, so a multiframe never mixes old and new settings.

Top module: `cas_sig_source`

## Requirements
- R1: While reset is high, `ser_out` is 0 one clock later. Reset clears the enable, all select bits and all signaling bytes, in both the staged and the working copy.
- R2: Every bit whose `slot_idx` is not 16 appears on `ser_out` unchanged, exactly one clock after it is presented on `ser_in`.
- R3: While the working enable is 0, timeslot 16 also passes through unchanged with one clock of latency, whatever the select bits hold.
- R4: While the enable is 1 and a nibble's governing select bit is 0, that nibble is taken from `ser_in`.
- R5: While the enable is 1, in frame n (1..15), the upper nibble (bit indices 0..3) is governed by channel n and the lower nibble (bit indices 4..7) by channel n+16. When the governing bit is 1, the output at bit index b is bit 7-b of signaling byte n, so bit 7 goes out first.
- R6: In frame 0, the upper nibble is governed by the channel 1 select bit and the lower nibble by the channel 17 select bit. Both nibbles come from signaling byte 0, which carries the alignment word and the spare and alarm bits.
- R7: Select register k (k = 0..3) bit j holds channel 8k+j+1. The select bits of channels 16 and 32 govern no nibble and have no effect.
- R8: Writes go to the staged copy. The working copy takes the staged copy at the clock edge where the input position is frame 0, timeslot 0, bit 0. A write accepted at that same edge takes effect one multiframe later.
- R9: The address map is as follows. Addresses 0..3 are the select registers. Address 4 bit 0 is the enable. Addresses 16..31 are signaling bytes 0..15. Writes to addresses 5..15 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial transmit data in |
| frame_idx | input | 4 | Frame number of the `ser_in` bit within the multiframe |
| slot_idx | input | 5 | Timeslot number of the `ser_in` bit |
| bit_idx | input | 3 | Bit index within the timeslot, 0 sent first |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| ser_out | output | 1 | Serial transmit data out, one clock behind `ser_in` |

## Verification
The assertions assume three things about the inputs. Reset is held high on the first clock edge. The inputs carry no unknown values after reset. The position inputs mark the multiframe start with an all-zero frame, timeslot and bit index. The stimulus follows this by walking a single 12-bit position counter in transmission order, so the all-zero position comes back every 4096 bits. Every input is driven on the falling edge. Register writes land at chosen positions, including mid-multiframe and exactly on the multiframe start, so the hold-until-boundary rule is exercised at both places.

// File: rtl/cas_pkg.sv
package cas_pkg;
    localparam int FRAMES    = 16;
    localparam int SLOTS     = 32;
    localparam int SLOT_BITS = 8;
    localparam int SIG_SLOT  = 16;
    localparam int CHANS     = 32;
    localparam int NIBBLE    = SLOT_BITS / 2;
    localparam int FW        = $clog2(FRAMES);
    localparam int TW        = $clog2(SLOTS);
    localparam int BW        = $clog2(SLOT_BITS);
    localparam int CW        = $clog2(CHANS);
    localparam int SEL_REGS  = CHANS / SLOT_BITS;
    localparam int SW        = $clog2(SEL_REGS);
    localparam int AW        = 5;
    localparam int ADDR_CTRL = 4;
    localparam int ADDR_SIG  = 16;

    typedef logic [SLOT_BITS-1:0] byte_t;

    typedef struct packed {
        logic [FW-1:0] frame;
        logic [TW-1:0] slot;
        logic [BW-1:0] bitn;
    } pos_t;

    typedef struct packed {
        logic                   en;
        logic [CHANS-1:0]       sel;
        byte_t [FRAMES-1:0]     sig;
    } cfg_t;

    typedef enum logic [1:0] {
        REG_SEL,
        REG_CTRL,
        REG_SIG,
        REG_NONE
    } reg_kind_e;

    function automatic reg_kind_e decode_addr(logic [AW-1:0] a);
        if (a >= AW'(ADDR_SIG))  return REG_SIG;
        if (a == AW'(ADDR_CTRL)) return REG_CTRL;
        if (a <  AW'(SEL_REGS))  return REG_SEL;
        return REG_NONE;
    endfunction

    function automatic logic is_mf_start(pos_t p);
        return p == '0;
    endfunction

    // Channel (0-based bit in the select vector) that governs the upper nibble
    function automatic logic [CW-1:0] upper_chan(int f);
        return (f == 0) ? '0 : CW'(f - 1);
    endfunction

    // Channel (0-based) that governs the lower nibble
    function automatic logic [CW-1:0] lower_chan(int f);
        return (f == 0) ? CW'(CHANS / 2) : CW'(f + CHANS / 2 - 1);
    endfunction
endpackage

// File: rtl/cas_cfg_regs.sv
module cas_cfg_regs
    import cas_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  byte_t         wr_data,
    input  logic          commit,
    output cfg_t          active
);
    cfg_t staged;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged <= '0;
            active <= '0;
        end else begin
            if (commit)
                active <= staged;
            if (wr_en) begin
                unique case (decode_addr(wr_addr))
                    REG_SEL:  staged.sel[wr_addr[SW-1:0]*SLOT_BITS +: SLOT_BITS] <= wr_data;
                    REG_CTRL: staged.en <= wr_data[0];
                    REG_SIG:  staged.sig[wr_addr[FW-1:0]] <= wr_data;
                    default:  ;
                endcase
            end
        end
    end
endmodule

// File: rtl/cas_ts16_mux.sv
module cas_ts16_mux
    import cas_pkg::*;
(
    input  pos_t pos,
    input  logic ser_in,
    input  cfg_t cfg,
    output logic bit_out
);
    logic [FRAMES-1:0] up_sel;
    logic [FRAMES-1:0] lo_sel;
    logic              unused_chan;

    for (genvar f = 0; f < FRAMES; f++) begin : g_frame
        assign up_sel[f] = cfg.sel[upper_chan(f)];
        assign lo_sel[f] = cfg.sel[lower_chan(f)];
    end

    // Channels 16 and 32 govern no nibble
    assign unused_chan = ^{cfg.sel[CHANS/2-1], cfg.sel[CHANS-1]};

    logic is_sig;
    logic upper;
    logic chan_sel;
    logic reg_bit;

    always_comb begin
        is_sig   = (pos.slot == TW'(SIG_SLOT));
        upper    = (pos.bitn < BW'(NIBBLE));
        chan_sel = upper ? up_sel[pos.frame] : lo_sel[pos.frame];
        reg_bit  = cfg.sig[pos.frame][BW'(SLOT_BITS-1) - pos.bitn];
        bit_out  = (cfg.en && is_sig && chan_sel) ? reg_bit : ser_in;
    end
endmodule

// File: rtl/cas_sig_source.sv
module cas_sig_source
    import cas_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ser_in,
    input  logic [FW-1:0] frame_idx,
    input  logic [TW-1:0] slot_idx,
    input  logic [BW-1:0] bit_idx,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    output logic          ser_out
);
    pos_t cur_pos;
    logic at_mf_start;
    cfg_t cfg_active;
    logic next_bit;

    assign cur_pos     = '{frame: frame_idx, slot: slot_idx, bitn: bit_idx};
    assign at_mf_start = is_mf_start(cur_pos);

    cas_cfg_regs u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .commit  (at_mf_start),
        .active  (cfg_active)
    );

    cas_ts16_mux u_mux (
        .pos     (cur_pos),
        .ser_in  (ser_in),
        .cfg     (cfg_active),
        .bit_out (next_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) ser_out <= 1'b0;
        else     ser_out <= next_bit;
    end
endmodule

// File: rtl/cas_sig_checker.sv
module cas_sig_checker
    import cas_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic ser_in,
    input pos_t pos,
    input logic ser_out,
    input cfg_t cfg_active,
    input logic mf_start
);
    p_reset_out_r1: assert property (@(posedge clk)
        rst |=> !ser_out);

    p_passthru_r2: assert property (@(posedge clk) disable iff (rst)
        (pos.slot != TW'(SIG_SLOT)) |=> (ser_out == $past(ser_in)));

    p_known_r2: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(ser_out));

    p_disabled_r3: assert property (@(posedge clk) disable iff (rst)
        !cfg_active.en |=> (ser_out == $past(ser_in)));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !mf_start |=> $stable(cfg_active));
endmodule

bind cas_sig_source cas_sig_checker u_cas_chk (
    .clk        (clk),
    .rst        (rst),
    .ser_in     (ser_in),
    .pos        (cur_pos),
    .ser_out    (ser_out),
    .cfg_active (cfg_active),
    .mf_start   (at_mf_start)
);

// File: tb/test_cas_sig_source.sv
module test_cas_sig_source;
    logic       clk = 1'b0;
    logic       rst;
    logic       ser_in;
    logic [3:0] frame_idx;
    logic [4:0] slot_idx;
    logic [2:0] bit_idx;
    logic       wr_en;
    logic [4:0] wr_addr;
    logic [7:0] wr_data;
    logic       ser_out;

    always #4 clk = ~clk;

    cas_sig_source i_cas_sig_source (
        .clk(clk), .rst(rst), .ser_in(ser_in), .frame_idx(frame_idx),
        .slot_idx(slot_idx), .bit_idx(bit_idx), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ser_out(ser_out)
    );

    int checks = 0;
    int errors = 0;
    int cnt    = 0;
    logic [15:0] lfsr = 16'hACE1;

    // Bench model of staged and working settings
    logic        st_en, ac_en;
    logic [31:0] st_sel, ac_sel;
    logic [7:0]  st_sig [16];
    logic [7:0]  ac_sig [16];

    logic  exp_valid;
    logic  exp_bit;
    string exp_tag;
    string tag_ovr = "";

    // {enable, select[31:0], signaling seed}
    localparam logic [40:0] VEC [6] = '{
        {1'b0, 32'hFFFF_FFFF, 8'hA5},   // R3: selects ignored
        {1'b1, 32'h0000_0000, 8'h5C},   // R4: all serial
        {1'b1, 32'hFFFF_FFFF, 8'h3C},   // R5 R6: all internal
        {1'b1, 32'h5A5B_C3A5, 8'hE7},   // mixed, ch1 and ch17 set
        {1'b1, 32'h8000_8000, 8'h99},   // R7: only ch16 and ch32
        {1'b1, 32'h0001_0000, 8'h0B}    // R6: only ch17
    };

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s pos %0d actual %0b expected %0b", tag, cnt, act, exp);
        end
    endtask

    task automatic model_reset();
        st_en = 0; ac_en = 0; st_sel = '0; ac_sel = '0;
        for (int i = 0; i < 16; i++) begin st_sig[i] = '0; ac_sig[i] = '0; end
    endtask

    // Called at a falling edge: check the previous bit, drive the next one
    task automatic tick();
        int f, ts, b, ch;
        string tg;
        if (exp_valid) check(exp_tag, ser_out, exp_bit);
        f  = cnt >> 8;
        ts = (cnt >> 3) & 31;
        b  = cnt & 7;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        ser_in    = lfsr[0];
        frame_idx = 4'(f);
        slot_idx  = 5'(ts);
        bit_idx   = 3'(b);
        if (ts != 16) begin
            exp_bit = ser_in; tg = "R2";
        end else if (!ac_en) begin
            exp_bit = ser_in; tg = "R3";
        end else begin
            if (b < 4) ch = (f == 0) ? 1 : f;
            else       ch = (f == 0) ? 17 : f + 16;
            if (ac_sel[ch-1]) begin
                exp_bit = ac_sig[f][7-b];
                tg = (f == 0) ? "R6 R7" : "R5 R7";
            end else begin
                exp_bit = ser_in; tg = "R4 R7";
            end
        end
        exp_tag   = (tag_ovr != "") ? tag_ovr : tg;
        exp_valid = 1'b1;
        if (cnt == 0) begin
            ac_en = st_en; ac_sel = st_sel;
            for (int i = 0; i < 16; i++) ac_sig[i] = st_sig[i];
        end
        if (wr_en) begin
            if (wr_addr < 4)        st_sel[wr_addr*8 +: 8] = wr_data;
            else if (wr_addr == 4)  st_en = wr_data[0];
            else if (wr_addr >= 16) st_sig[wr_addr-16] = wr_data;
        end
        cnt = (cnt + 1) % 4096;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic run_until(input int target);
        while (cnt != target) tick();
    endtask

    task automatic load(input logic en, input logic [31:0] sel, input logic [7:0] seed);
        for (int k = 0; k < 4; k++) wr(k, sel[k*8 +: 8]);
        for (int n = 0; n < 16; n++) wr(16 + n, seed ^ 8'(n * 37));
        wr(4, {7'b0, en});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, actual >= 190000 cycles expected fewer");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; ser_in = 0; frame_idx = 0; slot_idx = 0; bit_idx = 0;
        wr_en = 0; wr_addr = 0; wr_data = 0; exp_valid = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", ser_out, 1'b0);
        rst = 1'b0;
        run(4200);                      // cleared settings: pass-through

        // Table walk
        foreach (VEC[i]) begin
            load(VEC[i][40], VEC[i][39:8], VEC[i][7:0]);
            run(8192);
        end

        // R8: write in the middle of a multiframe is held back
        load(1'b1, 32'hFFFF_FFFF, 8'h6D);
        run_until(0);
        run(5 * 256);
        wr(4, 8'h00);
        tag_ovr = "R8";
        run_until(1);
        tag_ovr = "";
        run(4096);

        // R8: write on the very start edge applies one multiframe later
        run_until(0);
        wr(4, 8'h01);
        tag_ovr = "R8";
        run(8192);
        tag_ovr = "";

        // R9: writes to unmapped addresses change nothing
        for (int a = 5; a < 16; a++) wr(a, 8'hFF ^ 8'(a));
        wr(5, 8'h00);
        tag_ovr = "R9";
        run(8192);
        tag_ovr = "";

        // R1: reset in the middle of operation clears the settings
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", ser_out, 1'b0);
        rst = 1'b0;
        model_reset();
        exp_valid = 1'b0;
        tag_ovr = "R1";
        run(8192);
        tag_ovr = "";
        tick();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule